// File: doc/BRIEF.md
# Thermal Register File Migration Sequencer

This block moves integer register traffic between a primary register file and a spare copy when the primary file gets too hot, and moves it back once the primary has cooled. It watches a filtered temperature reading of the primary file against a high and a low threshold. It stalls issue and waits for pending writebacks to retire. It then emits a sequence of copy beats, four registers per beat, that a register-file pair outside the block carries out. Finally it flips the active-file select.

While the spare file is in use, every integer register access pays two extra cycles. The block raises a flag so the pipeline can add that latency. If the temperature keeps climbing past a margin above the high threshold while the spare file is active, the block asks a separate toggling throttle to engage. Migration alone cannot bound the temperature.

The storage and the pipeline are outside the block. The block produces only control: the stall request, copy addresses and enables, the direction of the copy, the active-file select, the latency flag and the fallback request.

Top module: `rf_migrate_top`

## Requirements
- R1: While the primary file is active and idle, a temperature at or above `thr_high` makes `stall_req` rise in the next cycle. It stays high through the drain and copy phases.
- R2: While `wb_pending` is high in a drain phase, no copy beat is issued. The first beat (`cp_rd_en`/`cp_wr_en` high, address 0) comes one cycle after the drain phase sees `wb_pending` low.
- R3: A copy is 20 consecutive beats with `cp_rd_addr` = `cp_wr_addr` = 0, 4, 8, … 76. Each beat covers four registers starting at that index. `cp_from_spare` is 0 when the copy goes primary-to-spare and 1 when it goes spare-to-primary.
- R4: In the cycle after the last beat, `active_spare` toggles and `stall_req` falls in that same cycle.
- R5: `extra_lat` is high exactly while `active_spare` is high. This is the interval in which each register access costs two extra cycles.
- R6: While the spare file is active and idle, a temperature at or below `thr_low` starts the reverse sequence: stall, drain, 20 beats spare-to-primary. After that, `active_spare` returns to 0.
- R7: A temperature strictly between `thr_low` and `thr_high` never starts a migration, whichever file is active.
- R8: Temperature changes during a drain or a copy do not alter that phase. The temperature is evaluated again only once the sequence has finished.
- R9: `fallback_req` is high when the spare file is active with no migration in progress and `temp` ≥ `thr_high` + 8. Otherwise it is low.
- R10: After reset, the primary file is active and `stall_req`, copy enables, `extra_lat` and `fallback_req` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| temp | input | 8 | Filtered primary-file temperature |
| thr_high | input | 8 | Migrate-away threshold |
| thr_low | input | 8 | Migrate-back threshold (below `thr_high`) |
| wb_pending | input | 1 | Writebacks still outstanding |
| stall_req | output | 1 | Issue stall request |
| cp_rd_en | output | 1 | Copy beat read enable on the source file |
| cp_rd_addr | output | 7 | First register of the beat, source file |
| cp_wr_en | output | 1 | Copy beat write enable on the destination file |
| cp_wr_addr | output | 7 | First register of the beat, destination file |
| cp_from_spare | output | 1 | 1: spare is the copy source; 0: primary is |
| active_spare | output | 1 | 1: integer accesses go to the spare file |
| extra_lat | output | 1 | Add two cycles to each register access |
| fallback_req | output | 1 | Engage the toggling throttle |

## Verification
The bench drives the temperature through four patterns: a cool level, a level inside the hysteresis band, a level above the high threshold, and a level above the fallback margin. Comparing the band level with the two threshold levels shows whether the thresholds are inclusive and whether hysteresis holds in both directions. Holding `wb_pending` high for several cycles separates a correct drain from a copy that starts early. Flipping the temperature to the opposite extreme in the middle of a copy separates a sequence that runs to completion from one that reacts too soon. A behavioural pair of 80-entry files, driven only by the copy outputs, shows whether every register arrives in the destination in both directions.

// File: rtl/rf_migrate_pkg.sv
package rf_migrate_pkg;

    typedef enum logic [2:0] {
        MS_PRIMARY  = 3'd0,
        MS_DRAIN_SP = 3'd1,
        MS_COPY_SP  = 3'd2,
        MS_SPARE    = 3'd3,
        MS_DRAIN_PR = 3'd4,
        MS_COPY_PR  = 3'd5
    } mig_state_e;

    typedef struct packed {
        logic hot;
        logic cool;
        logic overheat;
    } therm_flags_t;

    function automatic logic st_copying(mig_state_e s);
        return (s == MS_COPY_SP) || (s == MS_COPY_PR);
    endfunction

    function automatic logic st_stalled(mig_state_e s);
        return (s == MS_DRAIN_SP) || (s == MS_COPY_SP) ||
               (s == MS_DRAIN_PR) || (s == MS_COPY_PR);
    endfunction

    function automatic logic st_on_spare(mig_state_e s);
        return (s == MS_SPARE) || (s == MS_DRAIN_PR) || (s == MS_COPY_PR);
    endfunction

endpackage

// File: rtl/rf_therm_cmp.sv
module rf_therm_cmp
    import rf_migrate_pkg::*;
#(
    parameter int TEMP_W    = 8,
    parameter int FB_MARGIN = 8
) (
    input  logic [TEMP_W-1:0] temp,
    input  logic [TEMP_W-1:0] thr_high,
    input  logic [TEMP_W-1:0] thr_low,
    output therm_flags_t      flags
);
    localparam int EXT_W = TEMP_W + 1;

    logic [EXT_W-1:0] fb_limit;

    always_comb begin
        fb_limit       = {1'b0, thr_high} + EXT_W'(FB_MARGIN);
        flags.hot      = (temp >= thr_high);
        flags.cool     = (temp <= thr_low);
        flags.overheat = ({1'b0, temp} >= fb_limit);
    end
endmodule

// File: rtl/rf_beat_ctr.sv
module rf_beat_ctr #(
    parameter int BEATS  = 20,
    parameter int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    output logic [BEAT_W-1:0] idx,
    output logic              last
);
    localparam logic [BEAT_W-1:0] LAST_IDX = BEAT_W'(BEATS - 1);

    assign last = run && (idx == LAST_IDX);

    always_ff @(posedge clk) begin
        if (rst || !run || last) idx <= '0;
        else                     idx <= idx + 1'b1;
    end

    assert_beat_bound_R3: assert property (@(posedge clk) disable iff (rst)
        run |-> (idx <= LAST_IDX));
endmodule

// File: rtl/rf_seq_fsm.sv
module rf_seq_fsm
    import rf_migrate_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  therm_flags_t flags,
    input  logic         wb_pending,
    input  logic         beat_last,
    output mig_state_e   state
);
    mig_state_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            MS_PRIMARY:  if (flags.hot)  nxt = MS_DRAIN_SP;
            MS_DRAIN_SP: if (!wb_pending) nxt = MS_COPY_SP;
            MS_COPY_SP:  if (beat_last)  nxt = MS_SPARE;
            MS_SPARE:    if (flags.cool) nxt = MS_DRAIN_PR;
            MS_DRAIN_PR: if (!wb_pending) nxt = MS_COPY_PR;
            MS_COPY_PR:  if (beat_last)  nxt = MS_PRIMARY;
            default:     nxt = MS_PRIMARY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= MS_PRIMARY;
        else     state <= nxt;
    end

    assert_drain_waits_R2: assert property (@(posedge clk) disable iff (rst)
        ((state == MS_DRAIN_SP || state == MS_DRAIN_PR) && wb_pending)
        |=> (state == $past(state)));

    assert_copy_runs_on_R8: assert property (@(posedge clk) disable iff (rst)
        (st_copying(state) && !beat_last) |=> (state == $past(state)));
endmodule

// File: rtl/rf_migrate_top.sv
module rf_migrate_top
    import rf_migrate_pkg::*;
#(
    parameter int TEMP_W    = 8,
    parameter int NUM_REGS  = 80,
    parameter int BEAT_REGS = 4,
    parameter int FB_MARGIN = 8,
    parameter int ADDR_W    = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TEMP_W-1:0] temp,
    input  logic [TEMP_W-1:0] thr_high,
    input  logic [TEMP_W-1:0] thr_low,
    input  logic              wb_pending,
    output logic              stall_req,
    output logic              cp_rd_en,
    output logic [ADDR_W-1:0] cp_rd_addr,
    output logic              cp_wr_en,
    output logic [ADDR_W-1:0] cp_wr_addr,
    output logic              cp_from_spare,
    output logic              active_spare,
    output logic              extra_lat,
    output logic              fallback_req
);
    localparam int BEATS  = NUM_REGS / BEAT_REGS;
    localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1;

    therm_flags_t      flags;
    mig_state_e        state;
    logic [BEAT_W-1:0] beat_idx;
    logic              beat_last;
    logic              copying;
    logic [ADDR_W-1:0] beat_base;

    rf_therm_cmp #(.TEMP_W(TEMP_W), .FB_MARGIN(FB_MARGIN)) u_cmp (
        .temp(temp), .thr_high(thr_high), .thr_low(thr_low), .flags(flags)
    );

    assign copying = st_copying(state);

    rf_beat_ctr #(.BEATS(BEATS), .BEAT_W(BEAT_W)) u_ctr (
        .clk(clk), .rst(rst), .run(copying), .idx(beat_idx), .last(beat_last)
    );

    rf_seq_fsm u_fsm (
        .clk(clk), .rst(rst), .flags(flags), .wb_pending(wb_pending),
        .beat_last(beat_last), .state(state)
    );

    always_comb begin
        beat_base     = ADDR_W'(beat_idx) * ADDR_W'(BEAT_REGS);
        stall_req     = st_stalled(state);
        active_spare  = st_on_spare(state);
        extra_lat     = active_spare;
        cp_rd_en      = copying;
        cp_wr_en      = copying;
        cp_rd_addr    = copying ? beat_base : '0;
        cp_wr_addr    = copying ? beat_base : '0;
        cp_from_spare = (state == MS_COPY_PR);
        fallback_req  = (state == MS_SPARE) && flags.overheat;
    end

    assert_stall_on_hot_R1: assert property (@(posedge clk) disable iff (rst)
        (state == MS_PRIMARY && flags.hot) |=> stall_req);

    assert_beat_step_R3: assert property (@(posedge clk) disable iff (rst)
        (cp_rd_en && !beat_last) |=>
        (cp_rd_en && cp_rd_addr == ADDR_W'($past(cp_rd_addr) + ADDR_W'(BEAT_REGS))));

    assert_swap_on_release_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(stall_req) |-> (active_spare != $past(active_spare)));

    assert_fallback_gated_R9: assert property (@(posedge clk) disable iff (rst)
        fallback_req |-> (active_spare && !stall_req));
endmodule

// File: tb/rf_migrate_top_test.sv
module rf_migrate_top_test;
    localparam int NREG = 80;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] temp = 8'd50;
    logic [7:0] thr_high = 8'd90;
    logic [7:0] thr_low = 8'd70;
    logic       wb_pending = 1'b0;
    logic       stall_req, cp_rd_en, cp_wr_en, cp_from_spare;
    logic       active_spare, extra_lat, fallback_req;
    logic [6:0] cp_rd_addr, cp_wr_addr;

    always #2.5 clk = ~clk;

    rf_migrate_top uut (
        .clk(clk), .rst(rst), .temp(temp), .thr_high(thr_high), .thr_low(thr_low),
        .wb_pending(wb_pending), .stall_req(stall_req), .cp_rd_en(cp_rd_en),
        .cp_rd_addr(cp_rd_addr), .cp_wr_en(cp_wr_en), .cp_wr_addr(cp_wr_addr),
        .cp_from_spare(cp_from_spare), .active_spare(active_spare),
        .extra_lat(extra_lat), .fallback_req(fallback_req)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit chk_on  = 1'b0;
    bit done    = 1'b0;

    // reference: 0 idle-primary, 1 drain-out, 2 copy-out, 3 idle-spare, 4 drain-back, 5 copy-back
    int mode = 0;
    int beat = 0;
    int prim_f [NREG];
    int spare_f[NREG];

    task automatic chk(string tag, string what, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            mode <= 0; beat <= 0;
        end else begin
            case (mode)
                0: if (temp >= thr_high) mode <= 1;
                1: if (!wb_pending) begin mode <= 2; beat <= 0; end
                2: if (beat == 19) begin mode <= 3; beat <= 0; end else beat <= beat + 1;
                3: if (temp <= thr_low) mode <= 4;
                4: if (!wb_pending) begin mode <= 5; beat <= 0; end
                5: if (beat == 19) begin mode <= 0; beat <= 0; end else beat <= beat + 1;
                default: mode <= 0;
            endcase
        end
    end

    always @(negedge clk) begin
        if (chk_on && !done) begin
            bit cp_exp;
            cp_exp = (mode == 2 || mode == 5);
            chk("R1", "stall_req", int'(stall_req), int'(mode == 1 || mode == 2 || mode == 4 || mode == 5));
            chk("R2", "cp_rd_en", int'(cp_rd_en), int'(cp_exp));
            chk("R2", "cp_wr_en", int'(cp_wr_en), int'(cp_exp));
            if (cp_exp) begin
                chk("R3", "cp_rd_addr", int'(cp_rd_addr), beat * 4);
                chk("R3", "cp_wr_addr", int'(cp_wr_addr), beat * 4);
                chk("R3", "cp_from_spare", int'(cp_from_spare), int'(mode == 5));
            end
            chk("R4", "active_spare", int'(active_spare), int'(mode >= 3));
            chk("R5", "extra_lat", int'(extra_lat), int'(mode >= 3));
            chk("R9", "fallback_req", int'(fallback_req),
                int'(mode == 3 && int'(temp) >= int'(thr_high) + 8));
            if (cp_rd_en) begin
                for (int i = 0; i < 4; i++) begin
                    if (cp_from_spare) prim_f[int'(cp_wr_addr) + i] = spare_f[int'(cp_rd_addr) + i];
                    else               spare_f[int'(cp_wr_addr) + i] = prim_f[int'(cp_rd_addr) + i];
                end
            end
        end
    end

    int cyc_cnt = 0;
    always @(posedge clk) begin
        cyc_cnt <= cyc_cnt + 1;
        if (cyc_cnt > 20000 && !done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog expired at %0t", $time);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic cyc(int n);
        repeat (n) begin @(negedge clk); #1; end
    endtask

    task automatic wait_mode(int m);
        while (mode != m) cyc(1);
    endtask

    initial begin
        for (int i = 0; i < NREG; i++) begin
            prim_f[i]  = 100 + 3 * i;
            spare_f[i] = 0;
        end
        repeat (3) @(posedge clk);
        #1 chk_on = 1'b1;
        @(negedge clk); #1;
        // R10 reset state
        chk("R10", "stall_req after reset", int'(stall_req), 0);
        chk("R10", "active_spare after reset", int'(active_spare), 0);
        chk("R10", "fallback_req after reset", int'(fallback_req), 0);
        rst = 1'b0;
        cyc(5);

        // R7 band temperature on primary
        temp = 8'd89;
        cyc(6);
        chk("R7", "no migration inside band", int'(active_spare | stall_req), 0);

        // R1/R2 trigger at threshold with writebacks outstanding
        temp = 8'd90; wb_pending = 1'b1;
        cyc(5);
        chk("R2", "no copy during drain", int'(cp_rd_en), 0);
        wb_pending = 1'b0;
        cyc(24);
        chk("R4", "spare active after copy", int'(active_spare), 1);
        for (int i = 0; i < NREG; i++)
            chk("R3", "spare contents", spare_f[i], 100 + 3 * i);

        // R9 fallback margin boundary
        temp = 8'd97; cyc(2);
        chk("R9", "no fallback below margin", int'(fallback_req), 0);
        temp = 8'd98; cyc(2);
        chk("R9", "fallback at margin", int'(fallback_req), 1);

        // R7 band on spare
        temp = 8'd71; cyc(6);
        chk("R7", "stays on spare inside band", int'(active_spare), 1);
        chk("R7", "no stall inside band", int'(stall_req), 0);

        // spare content changes while in use
        for (int i = 0; i < NREG; i++) spare_f[i] = 5000 + i;

        // R6 return, R8 hot reading during reverse copy ignored
        temp = 8'd70; wb_pending = 1'b1;
        cyc(3);
        wb_pending = 1'b0;
        wait_mode(5);
        temp = 8'd120;
        wait_mode(0);
        cyc(1);
        for (int i = 0; i < NREG; i++)
            chk("R6", "primary contents after return", prim_f[i], 5000 + i);
        // hot again: new migration begins right after return (R8)
        chk("R8", "re-evaluated after copy", int'(stall_req), 1);
        wait_mode(2);
        temp = 8'd40; // cool reading during forward copy (R8)
        wait_mode(3);
        cyc(1);
        chk("R8", "copy finished before cool acted", int'(active_spare), 1);
        wait_mode(0);
        cyc(3);
        chk("R6", "back on primary", int'(active_spare), 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule